// File: doc/BRIEF.md
# Two-Wire Serial Slave Bit Front End

This block sits between the two pins of a two-wire serial bus (clock line and bidirectional open-drain data line) and a byte-level slave controller. Both pins are sampled by a fast system clock. Each one passes through a synchronizer and then a counter-based spike filter. The filtered levels are turned into single-cycle events: bus clock rising, bus clock falling, Start and Stop. A shift engine uses these events to shift in received bits MSB first. On the ninth clock of every byte it samples the acknowledge level. It also drives the data line low through an output enable, either to acknowledge a byte or to send read data.

The controller sees four one-cycle strobes: a byte was received, the ninth-clock level was sampled, a Start was seen, and a Stop was seen. It supplies three things in return: a byte to send, a load request that is taken at the end of a ninth clock, and an acknowledge request that is taken at the eighth falling edge. The data pin is never driven high. The output enable only pulls the line low.

Top module: `i2c_bit_front`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `sda_oe`, `rx_strobe`, `ack_strobe`, `start_seen` and `stop_seen` are all 0.
- R2: Each input passes through `SYNC_LEN` synchronizer flops and then a filter. The filtered level takes a new value only after the synchronized input has differed from it for `FILT_CYC` consecutive clocks. A pulse shorter than `FILT_CYC` clocks is therefore ignored, and a pulse of exactly `FILT_CYC` clocks passes.
- R3: A filtered data fall while the filtered clock is high on two consecutive samples gives a one-cycle `start_seen`. A filtered data rise under the same clock condition gives a one-cycle `stop_seen`. The two strobes are never high together.
- R4: After a Start, the data level at each of the first eight filtered clock rises is shifted in MSB first. `rx_strobe` pulses for one cycle after the eighth rise, and `rx_byte` then holds the byte.
- R5: At the ninth rise, `ack_strobe` pulses for one cycle and `ack_level` holds the sampled data level (0 = ACK, 1 = NACK).
- R6: If `ack_drive` is 1 at the eighth filtered clock fall, `sda_oe` goes to 1 (line pulled low). It returns to 0 at the ninth fall. `sda_oe` changes only after a filtered clock fall, a Start or a Stop.
- R7: If `tx_load` is 1 at the ninth fall, `tx_byte` is captured and its bit 7 is put on the line. Each later fall moves to the next lower bit, with `sda_oe = 1` for a 0 bit. The line is released at the eighth fall.
- R8: A Start or Stop in the middle of a byte discards the partial byte without a strobe and restarts the bit count. The byte that follows a repeated Start is received intact.
- R9: Clock edges before the first Start, or after a Stop, produce no `rx_strobe`, no `ack_strobe` and no change of `sda_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock pin level |
| sda_i | input | 1 | Raw bus data pin level |
| sda_oe | output | 1 | 1 pulls the data line low |
| tx_byte | input | DW | Byte to transmit, captured at the ninth fall |
| tx_load | input | 1 | Load `tx_byte` at the ninth fall and transmit it |
| ack_drive | input | 1 | Acknowledge the current byte (sampled at the eighth fall) |
| rx_byte | output | DW | Last received byte |
| rx_strobe | output | 1 | One-cycle pulse: a byte was received |
| ack_strobe | output | 1 | One-cycle pulse: the ninth-clock level was sampled |
| ack_level | output | 1 | Ninth-clock level, 0 = ACK, 1 = NACK |
| start_seen | output | 1 | One-cycle pulse: Start or repeated Start |
| stop_seen | output | 1 | One-cycle pulse: Stop |

## Verification
The hardest case to reach is the one where the block's own output enable feeds back through the data pin. The bench closes that loop: the line it drives is the wired AND of the bus master's level and the inverted `sda_oe`. Acknowledge and read-data bits therefore come back through the filter exactly as they would on a board. The other hard cases are spikes one clock shorter than the filter window, and a repeated Start after only four data bits. Both are produced by a cycle-counted master model, and the resulting filtered levels and strobes are compared on every clock against a behavioural reference.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_ev_t;
endpackage

// File: rtl/i2cfe_filter.sv
module i2cfe_filter #(
   parameter int SYNC_LEN = 2,
   parameter int FILT_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   logic [SYNC_LEN-1:0] sync_q;
   logic                clean_q;
   logic                settled;

   initial assert (SYNC_LEN >= 2) else $error("SYNC_LEN below 2");
   initial assert (FILT_CYC >= 0) else $error("FILT_CYC negative");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_LEN-2:0], raw};
   end
   assign settled = sync_q[SYNC_LEN-1];

   generate
      if (FILT_CYC <= 1) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clean_q <= 1'b1;
            else        clean_q <= settled;
         end
      end else begin : g_count
         localparam int CW = $clog2(FILT_CYC + 1);
         localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q   <= '0;
               clean_q <= 1'b1;
            end else if (settled == clean_q) begin
               run_q <= '0;
            end else if (run_q == LAST) begin
               run_q   <= '0;
               clean_q <= settled;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   assign clean = clean_q;

   // R2: a new filtered level always comes from the synchronized input
   assert_filt_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clean_q) |-> clean_q == $past(settled));
   // R2: agreement between input and output keeps the output still
   assert_filt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (settled == clean_q) |=> $stable(clean_q));
endmodule

// File: rtl/i2cfe_edges.sv
module i2cfe_edges
   import i2cfe_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_c,
   input  logic    sda_c,
   output bus_ev_t ev
);
   logic scl_prev_q, sda_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev_q <= 1'b1;
         sda_prev_q <= 1'b1;
      end else begin
         scl_prev_q <= scl_c;
         sda_prev_q <= sda_c;
      end
   end

   always_comb begin
      ev.scl_rise = scl_c & ~scl_prev_q;
      ev.scl_fall = ~scl_c & scl_prev_q;
      ev.start    = scl_c & scl_prev_q & sda_prev_q & ~sda_c;
      ev.stop     = scl_c & scl_prev_q & ~sda_prev_q & sda_c;
   end

   // R3: Start and Stop are never reported in the same cycle
   assert_start_stop_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev.start && ev.stop));
endmodule

// File: rtl/i2cfe_shifter.sv
module i2cfe_shifter
   import i2cfe_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bus_ev_t       ev,
   input  logic          sda_c,
   input  logic [DW-1:0] tx_byte,
   input  logic          tx_load,
   input  logic          ack_drive,
   output logic          sda_oe,
   output logic [DW-1:0] rx_byte,
   output logic          rx_strobe,
   output logic          ack_strobe,
   output logic          ack_level,
   output logic          start_seen,
   output logic          stop_seen
);
   localparam int CNTW = $clog2(DW + 2);
   localparam logic [CNTW-1:0] ACK_SLOT = CNTW'(DW);
   localparam logic [CNTW-1:0] LAST_BIT = CNTW'(DW - 1);
   localparam logic [CNTW-1:0] DONE     = CNTW'(DW + 1);

   initial assert (DW >= 2) else $error("DW below 2");

   logic            active_q, tx_on_q, oe_q;
   logic [CNTW-1:0] cnt_q;
   logic [DW-1:0]   rx_q, tx_q;
   logic            rxv_q, ackv_q, nack_q, start_q, stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         tx_on_q  <= 1'b0;
         oe_q     <= 1'b0;
         cnt_q    <= '0;
         rx_q     <= '0;
         tx_q     <= '0;
         rxv_q    <= 1'b0;
         ackv_q   <= 1'b0;
         nack_q   <= 1'b0;
         start_q  <= 1'b0;
         stop_q   <= 1'b0;
      end else begin
         rxv_q   <= 1'b0;
         ackv_q  <= 1'b0;
         start_q <= 1'b0;
         stop_q  <= 1'b0;
         if (ev.start || ev.stop) begin
            active_q <= ev.start;
            cnt_q    <= '0;
            oe_q     <= 1'b0;
            tx_on_q  <= 1'b0;
            start_q  <= ev.start;
            stop_q   <= ev.stop;
         end else if (active_q) begin
            if (ev.scl_rise) begin
               if (cnt_q < ACK_SLOT) begin
                  rx_q  <= {rx_q[DW-2:0], sda_c};
                  cnt_q <= cnt_q + 1'b1;
                  rxv_q <= (cnt_q == LAST_BIT);
               end else if (cnt_q == ACK_SLOT) begin
                  ackv_q <= 1'b1;
                  nack_q <= sda_c;
                  cnt_q  <= DONE;
               end
            end else if (ev.scl_fall) begin
               if (cnt_q == DONE) begin
                  cnt_q   <= '0;
                  tx_on_q <= tx_load;
                  tx_q    <= tx_byte;
                  oe_q    <= tx_load & ~tx_byte[DW-1];
               end else if (cnt_q == ACK_SLOT) begin
                  tx_on_q <= 1'b0;
                  oe_q    <= ack_drive;
               end else if (cnt_q != '0 && tx_on_q) begin
                  tx_q <= tx_q << 1;
                  oe_q <= ~tx_q[DW-2];
               end
            end
         end
      end
   end

   assign sda_oe     = oe_q;
   assign rx_byte    = rx_q;
   assign rx_strobe  = rxv_q;
   assign ack_strobe = ackv_q;
   assign ack_level  = nack_q;
   assign start_seen = start_q;
   assign stop_seen  = stop_q;

   // R4 R5: byte and ninth-clock strobes never coincide
   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rxv_q && ackv_q));
   // R9: no receive strobe outside a framed transfer
   assert_rx_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rxv_q || ackv_q) |-> active_q);
   // R6: the pad enable moves only after a clock fall or a bus condition
   assert_oe_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oe_q) |-> $past(ev.scl_fall || ev.start || ev.stop));
endmodule

// File: rtl/i2c_bit_front.sv
module i2c_bit_front
   import i2cfe_pkg::*;
#(
   parameter int SYNC_LEN = 2,
   parameter int FILT_CYC = 8,
   parameter int DW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   input  logic [DW-1:0] tx_byte,
   input  logic          tx_load,
   input  logic          ack_drive,
   output logic [DW-1:0] rx_byte,
   output logic          rx_strobe,
   output logic          ack_strobe,
   output logic          ack_level,
   output logic          start_seen,
   output logic          stop_seen
);
   logic    scl_c, sda_c;
   bus_ev_t ev;

   i2cfe_filter #(.SYNC_LEN(SYNC_LEN), .FILT_CYC(FILT_CYC)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .raw(scl_i), .clean(scl_c));

   i2cfe_filter #(.SYNC_LEN(SYNC_LEN), .FILT_CYC(FILT_CYC)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .raw(sda_i), .clean(sda_c));

   i2cfe_edges u_edges (
      .clk(clk), .rst_n(rst_n), .scl_c(scl_c), .sda_c(sda_c), .ev(ev));

   i2cfe_shifter #(.DW(DW)) u_shift (
      .clk(clk), .rst_n(rst_n), .ev(ev), .sda_c(sda_c),
      .tx_byte(tx_byte), .tx_load(tx_load), .ack_drive(ack_drive),
      .sda_oe(sda_oe), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
      .ack_strobe(ack_strobe), .ack_level(ack_level),
      .start_seen(start_seen), .stop_seen(stop_seen));
endmodule

// File: tb/test_i2c_bit_front.sv
`timescale 1ns/100ps
module test_i2c_bit_front;
   localparam int SYNC = 2;
   localparam int FILT = 6;
   localparam int Q    = 20;
   localparam int H    = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [7:0] tx_byte = 8'h00;
   logic tx_load = 1'b0, ack_drive = 1'b0;
   logic sda_oe, rx_strobe, ack_strobe, ack_level, start_seen, stop_seen;
   logic [7:0] rx_byte;
   wire  sda_line = sda_m & ~sda_oe;

   int checks = 0, errors = 0;
   int n_start = 0, n_stop = 0;
   logic [7:0] rx_log[$];
   bit         ack_log[$];

   always #2.5 clk = ~clk;

   i2c_bit_front #(.SYNC_LEN(SYNC), .FILT_CYC(FILT), .DW(8)) i_i2c_bit_front (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .tx_byte(tx_byte), .tx_load(tx_load),
      .ack_drive(ack_drive), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
      .ack_strobe(ack_strobe), .ack_level(ack_level),
      .start_seen(start_seen), .stop_seen(stop_seen));

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic [SYNC-1:0] rh_scl = '1, rh_sda = '1;
   logic [FILT-1:0] dh_scl = '1, dh_sda = '1;
   logic f_scl = 1, p_scl = 1, f_sda = 1, p_sda = 1;
   bit   m_act = 0, m_txon = 0;
   int   m_rises = 0;
   logic [7:0] m_tx = 0, e_rx = 0;
   logic e_oe = 0, e_rxv = 0, e_ackv = 0, e_nack = 0, e_start = 0, e_stop = 0;

   task automatic filt_step(input logic raw, inout logic [SYNC-1:0] rh,
                            inout logic [FILT-1:0] dh, inout logic lvl);
      logic d;
      d  = rh[SYNC-1];
      rh = {rh[SYNC-2:0], raw};
      dh = {dh[FILT-2:0], d};
      if (lvl ? (dh == '0) : (dh == '1)) lvl = d;
   endtask

   task automatic model_step(input logic raw_scl, input logic raw_sda);
      bit rise, fall, st, sp;
      rise = f_scl && !p_scl;
      fall = !f_scl && p_scl;
      st   = f_scl && p_scl && p_sda && !f_sda;
      sp   = f_scl && p_scl && !p_sda && f_sda;
      e_rxv = 0; e_ackv = 0; e_start = 0; e_stop = 0;
      if (st || sp) begin
         m_act = st; m_rises = 0; e_oe = 0; m_txon = 0;
         e_start = st; e_stop = sp;
      end else if (m_act && rise) begin
         if (m_rises < 8) begin
            e_rx[7 - m_rises] = f_sda;
            m_rises++;
            e_rxv = (m_rises == 8);
         end else if (m_rises == 8) begin
            e_ackv = 1; e_nack = f_sda; m_rises = 9;
         end
      end else if (m_act && fall) begin
         if (m_rises == 9) begin
            m_rises = 0; m_txon = tx_load; m_tx = tx_byte;
            e_oe = tx_load && !tx_byte[7];
         end else if (m_rises == 8) begin
            m_txon = 0; e_oe = ack_drive;
         end else if (m_rises > 0 && m_txon) begin
            e_oe = !m_tx[7 - m_rises];
         end
      end
      p_scl = f_scl; p_sda = f_sda;
      filt_step(raw_scl, rh_scl, dh_scl, f_scl);
      filt_step(raw_sda, rh_sda, dh_sda, f_sda);
   endtask

   // compare every clock, then advance the model by the coming edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         chk(sda_oe === e_oe && rx_strobe === e_rxv && ack_strobe === e_ackv &&
             start_seen === e_start && stop_seen === e_stop &&
             (!e_rxv || rx_byte === e_rx) && (!e_ackv || ack_level === e_nack),
             "R2 R3 R4 R5 R6 R7 per-cycle outputs {oe,rxv,ackv,st,sp}",
             {sda_oe, rx_strobe, ack_strobe, start_seen, stop_seen},
             {e_oe, e_rxv, e_ackv, e_start, e_stop});
         if (rx_strobe)  rx_log.push_back(rx_byte);
         if (ack_strobe) ack_log.push_back(ack_level);
         if (start_seen) n_start++;
         if (stop_seen)  n_stop++;
         model_step(scl_m, sda_line);
      end
   end

   // ---------------- bus master ----------------
   task automatic wc(input int n); repeat (n) @(negedge clk); endtask

   task automatic send_bit(input logic b, output logic seen);
      sda_m = b; wc(Q);
      scl_m = 1; wc(H/2); seen = sda_line; wc(H/2);
      scl_m = 0; wc(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic mack,
                            output logic ack_seen, output logic [7:0] rd);
      for (int i = 7; i >= 0; i--) send_bit(b[i], rd[i]);
      send_bit(mack, ack_seen);
   endtask

   task automatic bus_start();   // from idle or with clock low
      sda_m = 1; wc(Q); scl_m = 1; wc(H/2); sda_m = 0; wc(H/2); scl_m = 0; wc(Q);
   endtask

   task automatic bus_stop();
      sda_m = 0; wc(Q); scl_m = 1; wc(H/2); sda_m = 1; wc(H);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog R1 R9 run hung actual=%0d expected=%0d", 150000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic a; logic [7:0] rd; int base_rx, base_st, base_sp;
      wc(3);
      chk(sda_oe === 0 && rx_strobe === 0 && ack_strobe === 0 &&
          start_seen === 0 && stop_seen === 0, "R1 outputs in reset",
          {sda_oe, rx_strobe, ack_strobe, start_seen, stop_seen}, 0);
      rst_n = 1; wc(1);
      chk(sda_oe === 0 && rx_strobe === 0 && start_seen === 0, "R1 after release",
          {sda_oe, rx_strobe, start_seen}, 0);
      wc(20);

      // write transaction with acknowledges: R4 R5 R6
      ack_drive = 1;
      bus_start();
      send_byte(8'hA4, 1'b1, a, rd);
      chk(a === 0, "R6 address acknowledged on line", a, 0);
      send_byte(8'h3C, 1'b1, a, rd);
      chk(a === 0, "R6 data acknowledged on line", a, 0);
      ack_drive = 0;
      bus_stop(); wc(20);
      chk(rx_log.size() == 2 && rx_log[0] == 8'hA4 && rx_log[1] == 8'h3C,
          "R4 received bytes", rx_log.size() == 2 ? {rx_log[0], rx_log[1]} : 0, 16'hA43C);
      chk(ack_log.size() == 2 && ack_log[1] == 0, "R5 ack level 0",
          ack_log.size(), 2);
      chk(n_start == 1 && n_stop == 1, "R3 start/stop counts", {n_start[7:0], n_stop[7:0]}, 16'h0101);

      // read transaction: R7, NACK R5
      ack_drive = 1; tx_load = 1; tx_byte = 8'h96;
      bus_start();
      send_byte(8'hA5, 1'b1, a, rd);
      tx_load = 0; ack_drive = 0; tx_byte = 8'h00;
      send_byte(8'hFF, 1'b1, a, rd);
      chk(rd === 8'h96, "R7 master read data", rd, 8'h96);
      chk(a === 1, "R7 line released at eighth fall for NACK", a, 1);
      bus_stop(); wc(20);
      chk(ack_log.size() == 4 && ack_log[3] == 1, "R5 NACK level", ack_log.size(), 4);
      chk(sda_oe === 0, "R7 released after read", sda_oe, 0);

      // spikes: R2
      base_st = n_start; base_sp = n_stop;
      sda_m = 0; wc(FILT - 1); sda_m = 1; wc(40);
      scl_m = 0; wc(FILT - 1); scl_m = 1; wc(40);
      chk(n_start == base_st && n_stop == base_sp, "R2 short spikes ignored",
          n_start - base_st, 0);
      sda_m = 0; wc(FILT); sda_m = 1; wc(40);
      chk(n_start == base_st + 1 && n_stop == base_sp + 1, "R2 full-width pulse passes",
          n_start - base_st, 1);

      // abort with repeated start: R8
      base_rx = rx_log.size(); base_st = n_start;
      bus_start();
      for (int i = 0; i < 4; i++) send_bit(i < 2, a);
      bus_start();
      send_byte(8'h5A, 1'b1, a, rd);
      bus_stop(); wc(20);
      chk(rx_log.size() == base_rx + 1, "R8 partial byte dropped", rx_log.size() - base_rx, 1);
      chk(rx_log[rx_log.size()-1] == 8'h5A, "R8 byte after repeated start",
          rx_log[rx_log.size()-1], 8'h5A);
      chk(n_start == base_st + 2, "R8 repeated start reported", n_start - base_st, 2);

      // idle clocks after stop: R9
      base_rx = rx_log.size();
      ack_drive = 1;
      for (int i = 0; i < 9; i++) begin scl_m = 0; wc(H/2); scl_m = 1; wc(H/2); end
      ack_drive = 0; wc(20);
      chk(rx_log.size() == base_rx, "R9 no byte outside frame", rx_log.size() - base_rx, 0);
      chk(sda_oe === 0, "R9 line untouched outside frame", sda_oe, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule